// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address that a synchronous SRAM array sees during a four-beat burst. When the chip is enabled and either of two address strobes is high, it captures an external address in a register. After that, the two lowest address bits step through the burst each cycle that the advance input is high. The upper bits keep the captured value for the whole burst. When neither a strobe nor the advance input is active, the address holds and the current beat repeats.

A static order-select input chooses between two beat sequences:

- **Linear (0):** the low bits count up from the start value and wrap modulo four.
- **Interleaved (1):** the low bits are the start bits exclusive-ORed with the beat number.

The interleaved value is the one an undriven, pulled-up pin gives. Bursts are optional. A controller may present a fresh address with a strobe on every cycle, and each address appears at the output on the following cycle with no dead cycles.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `burst_addr` is zero after that edge.
- R2: A clock edge with `chip_en` and `stb_a` high makes `burst_addr` equal to `ext_addr` from that edge, on the next cycle.
- R3: A clock edge with `chip_en` and `stb_b` high makes `burst_addr` equal to `ext_addr` from that edge, on the next cycle.
- R4: A strobe at an edge where `chip_en` is low has no effect. With `adv` low, `burst_addr` keeps its value.
- R5: With `order_sel`=0, after k advances since a load with start low bits s, the low two bits of `burst_addr` equal (s+k) mod 4.
- R6: With `order_sel`=1, after k advances since a load with start low bits s, the low two bits of `burst_addr` equal s XOR (k mod 4).
- R7: An edge with no accepted strobe and `adv` low leaves `burst_addr` unchanged.
- R8: An accepted strobe takes priority over `adv` in the same cycle. The output becomes `ext_addr` with beat count zero.
- R9: Between loads, `burst_addr[ADDR_W-1:2]` never changes.
- R10: Loads on consecutive cycles each appear at the output one cycle later, with no idle cycle between them.
- R11: After four advances, the low bits return to the start value in both orders.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Qualifies both address strobes |
| stb_a | input | 1 | First address strobe, loads `ext_addr` |
| stb_b | input | 1 | Second address strobe, loads `ext_addr` |
| adv | input | 1 | Advance the burst by one beat |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External address to capture |
| burst_addr | output | ADDR_W | Address presented to the array |

## Verification
The hardest case is the wrap past the fourth beat from every start value, in both orders. Reaching it needs a load followed by an unbroken run of advances. The bench therefore sweeps all four start values, both strobes and both orders. Each load is followed by five advances with a hold cycle in the middle, so the wrap and the repeated beat are both checked at known counts. Priority is tested by raising `adv` together with a strobe, and by strobing while the chip is disabled.

// File: rtl/burst_pkg.sv
package burst_pkg;
    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } burst_cmd_e;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    function automatic beat_t map_beat(beat_t start, beat_t cnt, burst_order_e ord);
        beat_t r;
        if (ord == ORD_LINEAR)
            r = start + cnt;
        else
            r = start ^ cnt;
        return r;
    endfunction
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
    import burst_pkg::*;
(
    input  logic       chip_en,
    input  logic       stb_a,
    input  logic       stb_b,
    input  logic       adv,
    output burst_cmd_e cmd
);
    logic take_addr;

    assign take_addr = chip_en && (stb_a || stb_b);

    // a captured address always wins over advancing the burst
    always_comb begin
        if (take_addr)
            cmd = CMD_LOAD;
        else if (adv)
            cmd = CMD_STEP;
        else
            cmd = CMD_HOLD;
    end
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
    import burst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  burst_cmd_e cmd,
    output beat_t      beat
);
    always_ff @(posedge clk) begin
        if (rst)
            beat <= '0;
        else begin
            case (cmd)
                CMD_LOAD: beat <= '0;
                CMD_STEP: beat <= beat + beat_t'(1);
                default:  beat <= beat;
            endcase
        end
    end
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  burst_cmd_e        cmd,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] base_addr
);
    always_ff @(posedge clk) begin
        if (rst)
            base_addr <= '0;
        else if (cmd == CMD_LOAD)
            base_addr <= ext_addr;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              stb_a,
    input  logic              stb_b,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int UPPER_W = ADDR_W - BEAT_W;

    burst_cmd_e        cmd;
    beat_t             beat;
    logic [ADDR_W-1:0] base_addr;
    beat_t             low_bits;

    burst_cmd_dec u_dec (
        .chip_en (chip_en),
        .stb_a   (stb_a),
        .stb_b   (stb_b),
        .adv     (adv),
        .cmd     (cmd)
    );

    burst_beat_cnt u_cnt (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd),
        .beat (beat)
    );

    burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .ext_addr  (ext_addr),
        .base_addr (base_addr)
    );

    assign low_bits = map_beat(base_addr[BEAT_W-1:0], beat, burst_order_e'(order_sel));

    generate
        if (UPPER_W > 0) begin : g_upper
            assign burst_addr = {base_addr[ADDR_W-1:BEAT_W], low_bits};
        end else begin : g_narrow
            assign burst_addr = low_bits[ADDR_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              chip_en,
    input logic              stb_a,
    input logic              stb_b,
    input logic              adv,
    input logic              order_sel,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [ADDR_W-1:0] burst_addr
);
    logic accept;
    assign accept = chip_en && (stb_a || stb_b);

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> burst_addr == '0); // R1

    AST_LOAD_TAKES_ADDR: assert property (@(posedge clk) disable iff (rst)
        accept |=> burst_addr == $past(ext_addr)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!accept && !adv) |=> ($stable(burst_addr) || order_sel != $past(order_sel))); // R7

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        !accept |=> burst_addr[ADDR_W-1:2] == $past(burst_addr[ADDR_W-1:2])); // R9

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
        (!accept && adv && !order_sel) |=>
            (order_sel || burst_addr[1:0] == 2'($past(burst_addr[1:0]) + 2'd1))); // R5
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .stb_a      (stb_a),
    .stb_b      (stb_b),
    .adv        (adv),
    .order_sel  (order_sel),
    .ext_addr   (ext_addr),
    .burst_addr (burst_addr)
);

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          chip_en = 1'b0;
    logic          stb_a = 1'b0;
    logic          stb_b = 1'b0;
    logic          adv = 1'b0;
    logic          order_sel = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] burst_addr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst        (rst),
        .chip_en    (chip_en),
        .stb_a      (stb_a),
        .stb_b      (stb_b),
        .adv        (adv),
        .order_sel  (order_sel),
        .ext_addr   (ext_addr),
        .burst_addr (burst_addr)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ce, input logic a, input logic b, input logic av,
                       input logic [AW-1:0] ea);
        @(negedge clk);
        chip_en = ce; stb_a = a; stb_b = b; adv = av; ext_addr = ea;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [1:0] exp_low(input logic ord, input logic [1:0] s, input int k);
        logic [1:0] kk;
        kk = 2'(k);
        return ord ? (s ^ kk) : 2'(s + kk);
    endfunction

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] base;
        logic [AW-1:0] held;
        int            k;

        // R1 reset
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 18'h3ffff);
        chk("R1", burst_addr, '0);
        cyc(1'b1, 1'b0, 1'b0, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;

        for (int ord = 0; ord < 2; ord++) begin
            order_sel = ord[0];
            for (int sb = 0; sb < 2; sb++) begin
                for (int s = 0; s < 4; s++) begin
                    base = {16'(16'h2a5c + s * 97 + sb * 13 + ord * 7), 2'(s)};
                    cyc(1'b1, sb == 0, sb == 1, 1'b0, base);
                    chk(sb == 0 ? "R2" : "R3", burst_addr, base);
                    k = 0;
                    for (int n = 0; n < 6; n++) begin
                        if (n == 2) begin
                            held = burst_addr;
                            cyc(1'b0, 1'b1, 1'b1, 1'b0, ~base);
                            chk("R7/R4", burst_addr, held);
                        end else begin
                            cyc(1'b0, 1'b0, 1'b0, 1'b1, ~base);
                            k++;
                            chk(ord == 0 ? "R5" : "R6", {14'b0, 2'(burst_addr[1:0])},
                                {16'b0, exp_low(ord[0], 2'(s), k)});
                            chk("R9", burst_addr[AW-1:2], base[AW-1:2]);
                            if (k == 4)
                                chk("R11", {16'b0, burst_addr[1:0]}, {16'b0, 2'(s)});
                        end
                    end
                end
            end
        end

        // R8: strobe with advance in same cycle
        order_sel = 1'b0;
        cyc(1'b1, 1'b1, 1'b0, 1'b0, 18'h01235);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
        cyc(1'b1, 1'b0, 1'b1, 1'b1, 18'h2bcd6);
        chk("R8", burst_addr, 18'h2bcd6);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, '0);
        chk("R8", burst_addr, 18'h2bcd7);

        // R4: disabled strobe ignored
        held = burst_addr;
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 18'h15555);
        chk("R4", burst_addr, held);
        cyc(1'b0, 1'b0, 1'b1, 1'b0, 18'h0aaaa);
        chk("R4", burst_addr, held);

        // R10: a fresh address every cycle
        for (int i = 0; i < 8; i++) begin
            base = 18'(32'h1f00 * i + 32'h0123 + i);
            cyc(1'b1, i[0], !i[0], i[1], base);
            chk("R10", burst_addr, base);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule